// File: doc/BRIEF.md
# Stereo Linear Volume and Peak Detector

This block sits on a stereo sample stream of 24-bit twos-complement words. Samples arrive one at a time with a side flag. Each word is scaled by a linear gain of (256 − atten)/256, where atten is that channel's 8-bit attenuation setting. The scaled word leaves the block one clock later. Each attenuation step removes 1/256 of full scale, about 0.39 %. An attenuation of zero leaves the word unchanged.

Alongside the gain path, each channel keeps a running peak of the absolute value of its incoming samples, taken before attenuation. A one-cycle read strobe with a channel select returns that channel's peak on the next clock and clears it. If a sample for the same channel arrives in that same cycle, the register restarts from that sample's magnitude instead of zero. A pair is a left sample followed by a right sample. Attenuation settings are captured when the left sample is accepted, so the two halves of a pair are always scaled with settings taken at the same moment.

Top module: `stereo_vol_peak`

## Requirements
- R1: After reset, out_valid is 0, out_sample is 0, rd_data is 0 and both peak registers read back as 0.
- R2: A sample accepted with in_valid=1 appears on out_sample one clock later with out_valid=1 and out_side equal to in_side (0 = left, 1 = right). The value is floor(in_sample × (256 − atten) / 256), rounded toward negative infinity. out_valid is 0 in the cycle after a clock with in_valid=0.
- R3: With atten equal to 0, out_sample equals in_sample exactly, including −2^23 and 2^23−1.
- R4: Left samples are scaled by vol_atten_l and right samples by vol_atten_r. Setting one channel does not change the other channel's output.
- R5: A left sample uses vol_atten_l as present at its acceptance, and vol_atten_r is captured at that same moment. A right sample uses the captured vol_atten_r. A change to vol_atten_r between a left sample and the following right sample has no effect until the next left sample.
- R6: Each channel's peak register holds the largest absolute input value seen since its last clear. Values are measured before attenuation, and −2^23 counts as 2^23−1.
- R7: rd_en=1 with rd_sel (0 = left, 1 = right) places that channel's peak on rd_data one clock later and clears the register. A second read with no sample in between returns 0.
- R8: If a read and a sample of the same channel fall in the same cycle, rd_data returns the peak from before that sample. The register then holds that sample's magnitude.
- R9: Reading one channel's peak leaves the other channel's peak unchanged.
- R10: rd_data changes only on a clock with rd_en=1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_side | input | 1 | Side of the sample: 0 left, 1 right |
| in_sample | input | 24 | Twos-complement input sample |
| vol_atten_l | input | 8 | Left attenuation setting |
| vol_atten_r | input | 8 | Right attenuation setting |
| out_valid | output | 1 | Scaled sample valid |
| out_side | output | 1 | Side of the scaled sample |
| out_sample | output | 24 | Scaled twos-complement sample |
| rd_en | input | 1 | Peak read-and-clear strobe |
| rd_sel | input | 1 | Peak channel: 0 left, 1 right |
| rd_data | output | 24 | Peak value returned by the last read |

## Verification
Both results are due exactly one clock after their stimulus. The scaled sample follows the accepting edge, and the peak value follows the read-strobe edge. A peak updated by a sample is therefore visible to a read issued on any later cycle. The bench drives inputs on the falling edge and deasserts them on the next falling edge. It compares outputs at that same falling edge, which is half a period after the edge that registered them. Expected scaled values come from a bench-side floor division on wide integers, and expected peaks come from a bench-side tracker.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int SAMPLE_W = 24;
  localparam int ATTEN_W  = 8;
  localparam int GAIN_W   = ATTEN_W + 2;
  localparam int PROD_W   = SAMPLE_W + GAIN_W;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic        [ATTEN_W-1:0]  atten_t;

  // Linear gain (2^ATTEN_W - a) / 2^ATTEN_W, floor rounding via arithmetic shift.
  function automatic sample_t apply_atten(input sample_t s, input atten_t a);
    logic signed [GAIN_W-1:0] g;
    logic signed [PROD_W-1:0] p;
    g = GAIN_W'(1 << ATTEN_W) - $signed({2'b00, a});
    p = PROD_W'(s) * PROD_W'(g);
    return p[SAMPLE_W+ATTEN_W-1:ATTEN_W];
  endfunction

  // Absolute value with the most negative code saturated to the most positive.
  function automatic logic [SAMPLE_W-1:0] abs_sat(input sample_t s);
    if (s == {1'b1, {(SAMPLE_W-1){1'b0}}})
      return {1'b0, {(SAMPLE_W-1){1'b1}}};
    else if (s < 0)
      return SAMPLE_W'(-s);
    else
      return SAMPLE_W'(s);
  endfunction
endpackage

// File: rtl/svp_gain_latch.sv
module svp_gain_latch
  import svp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  logic   side,
  input  atten_t atten_l,
  input  atten_t atten_r,
  output atten_t atten_sel
);
  atten_t eff_r_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      eff_r_q <= '0;
    else if (load)
      eff_r_q <= atten_r;
  end

  assign atten_sel = side ? eff_r_q : atten_l;

  // R5
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(eff_r_q));
endmodule

// File: rtl/svp_scaler.sv
module svp_scaler
  import svp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  logic    in_side,
  input  sample_t in_sample,
  input  atten_t  atten,
  output logic    out_valid,
  output logic    out_side,
  output sample_t out_sample
);
  sample_t scaled;
  assign scaled = apply_atten(in_sample, atten);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_side   <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_side   <= in_side;
        out_sample <= scaled;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_side == $past(in_side));
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && atten == '0 |=> out_sample == $past(in_sample));
endmodule

// File: rtl/svp_peak.sv
module svp_peak
  import svp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_hit,
  input  sample_t             smp,
  input  logic                rd_clr,
  output logic [SAMPLE_W-1:0] peak_q
);
  logic [SAMPLE_W-1:0] mag;
  logic [SAMPLE_W-1:0] base;
  logic                grows;

  assign mag   = abs_sat(smp);
  assign base  = rd_clr ? '0 : peak_q;
  assign grows = smp_hit && (mag > base);

  always_ff @(posedge clk) begin
    if (!rst_n)
      peak_q <= '0;
    else if (grows)
      peak_q <= mag;
    else
      peak_q <= base;
  end

  // R7
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !smp_hit |=> peak_q == '0);
  // R6
  peak_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> peak_q >= $past(peak_q));
  // R8
  read_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && smp_hit |=> peak_q == $past(mag));
  // R6
  peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_q[SAMPLE_W-1] == 1'b0);
endmodule

// File: rtl/stereo_vol_peak.sv
module stereo_vol_peak
  import svp_pkg::*;
#(
  parameter int CHANNELS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_side,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [ATTEN_W-1:0]  vol_atten_l,
  input  logic [ATTEN_W-1:0]  vol_atten_r,
  output logic                out_valid,
  output logic                out_side,
  output logic [SAMPLE_W-1:0] out_sample,
  input  logic                rd_en,
  input  logic                rd_sel,
  output logic [SAMPLE_W-1:0] rd_data
);
  atten_t              atten_sel;
  logic                left_accept;
  sample_t             out_s;
  logic [SAMPLE_W-1:0] peak [CHANNELS];

  assign left_accept = in_valid && !in_side;

  svp_gain_latch u_gain (
    .clk(clk), .rst_n(rst_n), .load(left_accept), .side(in_side),
    .atten_l(vol_atten_l), .atten_r(vol_atten_r), .atten_sel(atten_sel)
  );

  svp_scaler u_scale (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_side(in_side),
    .in_sample($signed(in_sample)), .atten(atten_sel),
    .out_valid(out_valid), .out_side(out_side), .out_sample(out_s)
  );
  assign out_sample = out_s;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic hit, clr;
    assign hit = in_valid && (int'(in_side) == c);
    assign clr = rd_en && (int'(rd_sel) == c);
    svp_peak u_peak (
      .clk(clk), .rst_n(rst_n), .smp_hit(hit), .smp($signed(in_sample)),
      .rd_clr(clr), .peak_q(peak[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= peak[rd_sel];
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R9
  other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_sel && !in_valid |=> peak[1] == $past(peak[1]));
endmodule

// File: tb/test_stereo_vol_peak.sv
module test_stereo_vol_peak;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_side = 1'b0;
  logic [23:0] in_sample = '0;
  logic [7:0]  vol_atten_l = '0, vol_atten_r = '0;
  logic        out_valid, out_side;
  logic [23:0] out_sample;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [23:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stereo_vol_peak i_stereo_vol_peak (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_side(in_side),
    .in_sample(in_sample), .vol_atten_l(vol_atten_l), .vol_atten_r(vol_atten_r),
    .out_valid(out_valid), .out_side(out_side), .out_sample(out_sample),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // {sample, atten} vectors for the left channel
  localparam logic [31:0] VECS [12] = '{
    {24'd1000, 8'd0},       {24'd1000, 8'd128},    {24'hFFFC18, 8'd128},
    {24'hFFFFFF, 8'd1},     {24'd1, 8'd255},       {24'hFFFFFF, 8'd255},
    {24'h7FFFFF, 8'd255},   {24'h800000, 8'd255},  {24'h800000, 8'd1},
    {24'd12345, 8'd77},     {24'hABCDEF, 8'd200},  {24'h3FFFFF, 8'd64}
  };

  function automatic logic [23:0] ref_scale(input logic [23:0] s, input logic [7:0] a);
    longint p, q;
    p = longint'($signed(s)) * (256 - longint'(a));
    q = p / 256;
    if (p < 0 && (p % 256) != 0) q = q - 1;
    return q[23:0];
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic side, input logic [23:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_side = side; in_sample = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic peek(input logic sel);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {23'd0, out_valid}, 24'd0);
    chk("R1 out_sample", out_sample, 24'd0);
    chk("R1 rd_data", rd_data, 24'd0);
    peek(1'b0);
    chk("R1 left peak", rd_data, 24'd0);

    // R2 table walk on the left channel
    for (int i = 0; i < 12; i++) begin
      vol_atten_l = VECS[i][7:0];
      send(1'b0, VECS[i][31:8]);
      chk("R2 valid", {23'd0, out_valid}, 24'd1);
      chk("R2 side", {23'd0, out_side}, 24'd0);
      chk("R2 scaled", out_sample, ref_scale(VECS[i][31:8], VECS[i][7:0]));
    end
    @(negedge clk);
    chk("R2 idle valid", {23'd0, out_valid}, 24'd0);
    peek(1'b0);

    // R3 unity
    vol_atten_l = 8'd0; vol_atten_r = 8'd0;
    send(1'b0, 24'h800000);
    chk("R3 min pass", out_sample, 24'h800000);
    send(1'b1, 24'h7FFFFF);
    chk("R3 max pass", out_sample, 24'h7FFFFF);
    chk("R3 right side", {23'd0, out_side}, 24'd1);

    // R4 independence
    vol_atten_l = 8'h40; vol_atten_r = 8'hC0;
    send(1'b0, 24'd4096);
    chk("R4 left", out_sample, ref_scale(24'd4096, 8'h40));
    send(1'b1, 24'd4096);
    chk("R4 right", out_sample, ref_scale(24'd4096, 8'hC0));

    // R5 pair boundary
    vol_atten_r = 8'h10;
    send(1'b0, 24'd100);
    vol_atten_r = 8'hF0;
    send(1'b1, 24'd8192);
    chk("R5 held right", out_sample, ref_scale(24'd8192, 8'h10));
    send(1'b0, 24'd100);
    send(1'b1, 24'd8192);
    chk("R5 next pair", out_sample, ref_scale(24'd8192, 8'hF0));

    // clear both peaks
    peek(1'b0); peek(1'b1);

    // R6 peak tracking, pre-attenuation
    vol_atten_l = 8'd255;
    send(1'b0, 24'd100);
    send(1'b0, -24'sd500);
    send(1'b0, 24'd20);
    peek(1'b0);
    chk("R6 left peak", rd_data, 24'd500);
    // R7 second read returns zero
    peek(1'b0);
    chk("R7 cleared", rd_data, 24'd0);
    // R6 saturation
    send(1'b1, 24'h800000);
    // R9 left read leaves right intact
    send(1'b0, 24'd7);
    peek(1'b0);
    chk("R9 left read", rd_data, 24'd7);
    peek(1'b1);
    chk("R6 saturated", rd_data, 24'h7FFFFF);

    // R8 same-cycle read and sample
    send(1'b0, 24'd300);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 1'b0;
    in_valid = 1'b1; in_side = 1'b0; in_sample = -24'sd900;
    @(negedge clk);
    rd_en = 1'b0; in_valid = 1'b0;
    chk("R8 old value", rd_data, 24'd300);
    peek(1'b0);
    chk("R8 reloaded", rd_data, 24'd900);

    // R10 hold
    repeat (4) @(negedge clk);
    chk("R10 hold", rd_data, 24'd900);
    send(1'b0, 24'd50);
    chk("R10 hold after sample", rd_data, 24'd900);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule